// File: doc/BRIEF.md
# Restartable Serial Transmitter with Odd Parity

This block turns a byte into an asynchronous serial frame on one output line. An external baud tick feeds a divide-by-16 prescaler, so each bit on the line lasts sixteen ticks. A write strobe with a data byte loads the frame, clears the prescaler so that bit timing lines up with the write, and starts a new frame at once. When the frame ends, the block pulses an interrupt for one cycle. A sticky pending flag, if one is wanted, lives outside the block.

The frame is built from these parts, sent in this order:

1. a low start bit;
2. eight bit slots, least significant bit first;
3. two high stop bits.

When the parity enable is high at the time of the write, the last bit slot carries an odd parity bit computed over the lower seven data bits. The hardware offers no even parity.

A write is never refused. A write in the middle of a frame drops that frame and starts a fresh start bit. Software can use this to hold the line low as a break: it writes zero bytes faster than a frame can finish.

Top module: `serial_tx_restart`

## Requirements
- R1: After reset the line output is high and the interrupt output is low.
- R2: The clock edge that takes a write drives the line low for the start bit. The start bit lasts 16 baud ticks counted from that write.
- R3: After the start bit, the bit slots follow at one slot per 16 ticks, least significant data bit first.
- R4: With parity enable high at the write, slot 7 is 1 when data bits 6..0 hold an even number of ones, and 0 otherwise. With parity enable low, slot 7 is data bit 7.
- R5: The block samples parity enable only on the write cycle. Changes during the frame do not alter the frame in progress.
- R6: Two high stop bits follow slot 7. After them the line stays high until the next write.
- R7: The interrupt output is high for exactly one clock cycle. That cycle follows the clock edge that takes the 176th tick after the write, which ends the second stop bit. The line is high during that cycle.
- R8: A write during a frame abandons that frame and clears the prescaler. The new frame then keeps the timing of R2 and R3, counted from the new write, and the dropped frame raises no interrupt.
- R9: Zero bytes written every 100 ticks keep the line low without a break for as long as the writes continue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Baud tick, one clock cycle wide |
| wr_i | input | 1 | Write strobe that loads the byte and restarts the frame |
| wr_data_i | input | 8 | Byte to transmit |
| par_en_i | input | 1 | Replace slot 7 with an odd parity bit |
| txd_o | output | 1 | Serial line, high when idle |
| done_irq_o | output | 1 | One-cycle pulse when a frame ends |

## Verification
The bench sends several bytes:

- alternating patterns such as 0xA5 and 0x5A, which show whether the bit order is reversed or shifted by a slot;
- 0x7F and 0x80 with parity on and off, which separate the parity value from the data bit 7 value;
- a frame whose parity enable flips mid-frame, which shows whether the enable is sampled only at the write.

A write in the middle of a bit checks that the prescaler clears and that no interrupt comes from the dropped frame. A run of zero writes that never let a frame finish shows whether the line ever rises during a break.

// File: rtl/tx_pkg.sv
package tx_pkg;
  localparam int unsigned TX_TICKS_PER_BIT = 16;
  localparam int unsigned TX_DATA_BITS     = 8;
  localparam int unsigned TX_STOP_BITS     = 2;
endpackage

// File: rtl/tx_prescaler.sv
module tx_prescaler #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic shift_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          shift_d;

  always_comb begin
    cnt_d   = cnt_q;
    shift_d = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i && tick_i) begin
      if (cnt_q == LAST) begin
        cnt_d   = '0;
        shift_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign shift_o = shift_d;

  // R8: a write clears the prescaler
  p_clear_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  // R3: the count moves only on ticks
  p_count_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter #(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned STOP_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic                 par_en_i,
  input  logic                 shift_i,
  output logic                 busy_o,
  output logic                 txd_o,
  output logic                 done_o
);
  localparam int unsigned FW  = 1 + DATA_BITS + STOP_BITS;
  localparam int unsigned BCW = $clog2(FW + 1);
  localparam logic [BCW-1:0] LAST_SLOT = BCW'(FW - 1);

  logic [FW-1:0]  sh_q, sh_d;
  logic [BCW-1:0] bcnt_q, bcnt_d;
  logic           busy_q, busy_d;
  logic           done_q, done_d;
  logic           top_slot;

  // odd parity: the slot makes the total count of ones odd
  assign top_slot = par_en_i ? ~(^data_i[DATA_BITS-2:0]) : data_i[DATA_BITS-1];

  always_comb begin
    sh_d   = sh_q;
    bcnt_d = bcnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (load_i) begin
      sh_d   = {{STOP_BITS{1'b1}}, top_slot, data_i[DATA_BITS-2:0], 1'b0};
      bcnt_d = '0;
      busy_d = 1'b1;
    end else if (busy_q && shift_i) begin
      sh_d = {1'b1, sh_q[FW-1:1]};
      if (bcnt_q == LAST_SLOT) begin
        bcnt_d = '0;
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        bcnt_d = bcnt_q + BCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      bcnt_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      bcnt_q <= bcnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = sh_q[0];
  assign done_o = done_q;

  // R6: an idle shifter holds the line high
  p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd_o);

  // R7: the end pulse lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R3: the frame moves only on a load or a shift
  p_shift_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !shift_i) |=> $stable(sh_q));
endmodule

// File: rtl/serial_tx_restart.sv
module serial_tx_restart
  import tx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = TX_TICKS_PER_BIT,
  parameter int unsigned DATA_BITS     = TX_DATA_BITS,
  parameter int unsigned STOP_BITS     = TX_STOP_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 wr_i,
  input  logic [DATA_BITS-1:0] wr_data_i,
  input  logic                 par_en_i,
  output logic                 txd_o,
  output logic                 done_irq_o
);
  logic [1:0] rs_q;
  logic       rst_sync_n;
  logic       shift;
  logic       busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  tx_prescaler #(.DIV(TICKS_PER_BIT)) u_presc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en_i    (busy),
    .clr_i   (wr_i),
    .tick_i  (tick_i),
    .shift_o (shift)
  );

  tx_frame_shifter #(.DATA_BITS(DATA_BITS), .STOP_BITS(STOP_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_i   (wr_i),
    .data_i   (wr_data_i),
    .par_en_i (par_en_i),
    .shift_i  (shift),
    .busy_o   (busy),
    .txd_o    (txd_o),
    .done_o   (done_irq_o)
  );

  // R2: the write edge starts the low start bit
  p_start_after_write_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_i |=> !txd_o);

  // R7: the line is high while the interrupt fires
  p_irq_line_high_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_irq_o |-> txd_o);

  // R8: a write cancels any pending end of frame
  p_write_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_i |=> !done_irq_o);
endmodule

// File: tb/tb_serial_tx_restart.sv
module tb_serial_tx_restart;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       par_en_i = 1'b0;
  logic       txd_o;
  logic       done_irq_o;

  int total = 0;
  int bad = 0;
  int tcnt = 0;
  bit tick_seen = 1'b0;
  bit mon_on = 1'b0;
  bit brk_mode = 1'b0;
  int brk_bad = 0;
  bit q[$];

  always #10 clk = ~clk;

  serial_tx_restart dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .wr_i       (wr_i),
    .wr_data_i  (wr_data_i),
    .par_en_i   (par_en_i),
    .txd_o      (txd_o),
    .done_irq_o (done_irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // driver: write a byte and queue the expected frame
  task automatic do_write(input logic [7:0] d, input bit p);
    @(negedge clk);
    wr_i = 1'b1; wr_data_i = d; par_en_i = p;
    q.delete();
    q.push_back(1'b0);
    for (int i = 0; i < 7; i++) q.push_back(d[i]);
    q.push_back(p ? ~(^d[6:0]) : d[7]);
    q.push_back(1'b1);
    q.push_back(1'b1);
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  // bench-side tick counter since the last write
  always @(posedge clk) begin
    tick_seen <= tick_i && !wr_i;
    if (wr_i) tcnt <= 0;
    else if (tick_i) tcnt <= tcnt + 1;
  end

  // monitor: compare mid-bit samples with the queue
  always @(negedge clk) begin
    if (mon_on) begin
      if (tick_seen && (tcnt % 16 == 8) && q.size() > 0) begin
        automatic int idx = tcnt / 16;
        automatic bit e = q.pop_front();
        automatic string tag = (idx == 0) ? "R2" : (idx == 8) ? "R4" :
                               (idx >= 9) ? "R6" : "R3";
        chk(txd_o === e, tag, int'(txd_o), int'(e));
      end
      if (tick_seen && tcnt == 176) chk(done_irq_o === 1'b1, "R7", int'(done_irq_o), 1);
      else if (done_irq_o !== 1'b0) chk(1'b0, "R7/R8 stray irq", int'(done_irq_o), 0);
      if (brk_mode && txd_o !== 1'b0) brk_bad++;
    end
  end

  initial begin
    #3_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(txd_o === 1'b1, "R1 line idle", int'(txd_o), 1);
    chk(done_irq_o === 1'b0, "R1 irq low", int'(done_irq_o), 0);
    mon_on = 1'b1;

    // R3 bit order patterns
    do_write(8'hA5, 1'b0); ticks(190);
    do_write(8'h5A, 1'b0); ticks(190);
    // R6 idle after frame
    ticks(30);
    chk(txd_o === 1'b1, "R6 idle high", int'(txd_o), 1);

    // R4 parity cases
    do_write(8'h7F, 1'b1); ticks(190);
    do_write(8'h80, 1'b1); ticks(190);
    do_write(8'h80, 1'b0); ticks(190);
    do_write(8'h01, 1'b1); ticks(190);

    // R5 parity enable changed mid-frame
    do_write(8'h00, 1'b1);
    ticks(40);
    par_en_i = 1'b0;
    ticks(150);

    // R8 overwrite mid-bit
    do_write(8'hFF, 1'b0);
    ticks(57);
    do_write(8'h3C, 1'b1);
    chk(txd_o === 1'b0, "R8 restart start bit", int'(txd_o), 0);
    ticks(190);

    // R9 break via repeated zero writes
    do_write(8'h00, 1'b0);
    brk_mode = 1'b1;
    for (int k = 0; k < 5; k++) begin
      ticks(100);
      do_write(8'h00, 1'b0);
    end
    ticks(100);
    brk_mode = 1'b0;
    chk(brk_bad == 0, "R9 break held low", brk_bad, 0);
    ticks(100);
    chk(txd_o === 1'b1, "R6 idle after break", int'(txd_o), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule